// File: doc/BRIEF.md
# Control Endpoint OUT Handshake Gate

This block sits between the packet decoder of a low-speed (1.5 Mb/s) USB device and the receive FIFO of its control endpoint. It tracks each SETUP or OUT data stage. It decides byte by byte whether the received data goes to the FIFO. At the end of the packet it chooses the handshake: ACK, NAK or silence.

Firmware arms reception of the next OUT data stage by writing a one into bit 4 of the endpoint control register. The gate samples that bit when an OUT token arrives. If the bit was set, the data is stored and acknowledged. If it was clear, the data is dropped and the host receives NAK. Hardware clears the bit in only two cases: when a SETUP stage is acknowledged, and when an OUT stage is acknowledged. The clear happens at the handshake, not at the token. A NAKed OUT leaves the bit alone.

A packet with a bad CRC gets no handshake and does not touch the bit. The gate also asks the FIFO to rewind its write pointer, so that the partial bytes are discarded.

Top module: `ep0_out_gate`

## Requirements
- R1: After a synchronous active-high reset, `out_en` is 0, `hs_sel` is 2'b00, `fifo_we` is 0 and `fifo_rewind` is 0.
- R2: A register write (`cfg_wr` high) loads `cfg_wdata[4]` into the enable. `out_en` shows the new value in the next cycle. The other data bits have no effect.
- R3: For an OUT token seen while the enable is 1, each later `byte_vld` of that packet raises `fifo_we` in the same cycle. `fifo_wdata` equals `byte_data` in that cycle.
- R4: For an OUT token seen while the enable is 0, no data byte raises `fifo_we`. A good-CRC end of packet yields `hs_sel` = 2'b10 (NAK) in the next cycle. The enable keeps whatever value firmware gives it.
- R5: For an enabled OUT with good CRC, `hs_sel` = 2'b01 (ACK) one cycle after `eop`, and `out_en` reads 0 from that same cycle. Through the token and the data bytes, `out_en` stays 1.
- R6: A SETUP stage stores every data byte and is answered with ACK, whatever the enable holds. A good SETUP clears the enable at its handshake.
- R7: An end of packet with `crc_ok` low gives `hs_sel` = 2'b00 in the next cycle and leaves the enable unchanged. In that same cycle, `fifo_rewind` pulses if any byte of the packet was written.
- R8: If a register write lands in the cycle of an ACK-producing end of packet, the hardware clear wins and `out_en` reads 0.
- R9: `hs_sel` is nonzero for exactly one cycle per handshake.
- R10: Data bytes and end-of-packet strobes that arrive with no open token write nothing and produce no handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Endpoint control register write strobe |
| cfg_wdata | input | 8 | Register write data; bit 4 is the OUT enable |
| tok_setup | input | 1 | SETUP token decoded for this endpoint |
| tok_out | input | 1 | OUT token decoded for this endpoint |
| byte_vld | input | 1 | Received data byte strobe |
| byte_data | input | 8 | Received data byte |
| eop | input | 1 | End of data packet |
| crc_ok | input | 1 | CRC status, valid with `eop` |
| fifo_we | output | 1 | FIFO write enable |
| fifo_wdata | output | 8 | FIFO write data |
| fifo_rewind | output | 1 | Discard bytes written for the current packet |
| hs_sel | output | 2 | Handshake strobe: 01 ACK, 10 NAK, 00 none |
| out_en | output | 1 | Readable state of the OUT enable |

## Verification
A firmware write to the enable and the hardware clear from an acknowledged stage can fall on the same clock edge. The bench provokes this by raising `cfg_wr` with bit 4 set in the very cycle that `eop` closes an enabled, good-CRC OUT packet. It passes when `out_en` reads 0 alongside the ACK strobe. The opposite case is also driven: a firmware write during a NAKed stage must survive. In that case `out_en` must read 1 after the NAK.

// File: rtl/ep0_out_gate.sv
module ep0_out_gate #(
  parameter int DW     = 8,
  parameter int EN_BIT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          tok_setup,
  input  logic          tok_out,
  input  logic          byte_vld,
  input  logic [DW-1:0] byte_data,
  input  logic          eop,
  input  logic          crc_ok,
  output logic          fifo_we,
  output logic [DW-1:0] fifo_wdata,
  output logic          fifo_rewind,
  output logic [1:0]    hs_sel,
  output logic          out_en
);
  localparam logic [1:0] HS_NONE = 2'b00;
  localparam logic [1:0] HS_ACK  = 2'b01;
  localparam logic [1:0] HS_NAK  = 2'b10;

  logic       en_q, open_q, setup_q, take_q, wrote_q, rew_q;
  logic [1:0] hs_q;

  wire closing = eop & open_q;
  wire good    = closing & crc_ok;
  wire acked   = good & (setup_q | take_q);

  assign fifo_we     = byte_vld & open_q & take_q;
  assign fifo_wdata  = byte_data;
  assign fifo_rewind = rew_q;
  assign hs_sel      = hs_q;
  assign out_en      = en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      open_q  <= 1'b0;
      setup_q <= 1'b0;
      take_q  <= 1'b0;
      wrote_q <= 1'b0;
      hs_q    <= HS_NONE;
      rew_q   <= 1'b0;
    end else begin
      if (tok_setup) begin
        open_q  <= 1'b1;
        setup_q <= 1'b1;
        take_q  <= 1'b1;
        wrote_q <= 1'b0;
      end else if (tok_out) begin
        open_q  <= 1'b1;
        setup_q <= 1'b0;
        take_q  <= en_q;
        wrote_q <= 1'b0;
      end else if (eop) begin
        open_q  <= 1'b0;
        wrote_q <= 1'b0;
      end else if (fifo_we) begin
        wrote_q <= 1'b1;
      end

      hs_q  <= good ? (acked ? HS_ACK : HS_NAK) : HS_NONE;
      rew_q <= closing & ~crc_ok & (wrote_q | fifo_we);

      if (acked)       en_q <= 1'b0;
      else if (cfg_wr) en_q <= cfg_wdata[EN_BIT];
    end
  end
endmodule

module ep0_out_gate_chk #(
  parameter int DW     = 8,
  parameter int EN_BIT = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_wr,
  input logic [DW-1:0] cfg_wdata,
  input logic          byte_vld,
  input logic          fifo_we,
  input logic          fifo_rewind,
  input logic [1:0]    hs_sel,
  input logic          out_en
);
  logic seen_rst;
  always_ff @(posedge clk) seen_rst <= rst | seen_rst;

  assert_reset_idle_R1: assert property (@(posedge clk)
    $rose(seen_rst) |-> (!out_en && hs_sel == 2'b00 && !fifo_rewind));

  assert_write_loads_R2: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    ($past(cfg_wr) && !$past(rst) && hs_sel != 2'b01) |-> out_en == $past(cfg_wdata[EN_BIT]));

  assert_we_needs_byte_R3: assert property (@(posedge clk) disable iff (rst)
    fifo_we |-> byte_vld);

  assert_nak_keeps_bit_R4: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    (hs_sel == 2'b10 && !$past(cfg_wr)) |-> out_en == $past(out_en));

  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (rst)
    hs_sel == 2'b01 |-> !out_en);

  assert_rewind_silent_R7: assert property (@(posedge clk) disable iff (rst)
    fifo_rewind |-> hs_sel == 2'b00);

  assert_hs_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
    hs_sel != 2'b00 |=> hs_sel == 2'b00);

  assert_hs_legal_R9: assert property (@(posedge clk) disable iff (rst)
    hs_sel != 2'b11);
endmodule

bind ep0_out_gate ep0_out_gate_chk #(.DW(DW), .EN_BIT(EN_BIT)) u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
  .byte_vld(byte_vld), .fifo_we(fifo_we), .fifo_rewind(fifo_rewind),
  .hs_sel(hs_sel), .out_en(out_en)
);

// File: tb/tb_ep0_out_gate.sv
module tb_ep0_out_gate;
  logic       clk = 1'b0;
  logic       rst, cfg_wr, tok_setup, tok_out, byte_vld, eop, crc_ok;
  logic [7:0] cfg_wdata, byte_data;
  logic       fifo_we, fifo_rewind, out_en;
  logic [7:0] fifo_wdata;
  logic [1:0] hs_sel;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  ep0_out_gate dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .tok_setup(tok_setup), .tok_out(tok_out), .byte_vld(byte_vld),
    .byte_data(byte_data), .eop(eop), .crc_ok(crc_ok),
    .fifo_we(fifo_we), .fifo_wdata(fifo_wdata), .fifo_rewind(fifo_rewind),
    .hs_sel(hs_sel), .out_en(out_en)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic quiet();
    cfg_wr = 0; cfg_wdata = 0; tok_setup = 0; tok_out = 0;
    byte_vld = 0; byte_data = 0; eop = 0; crc_ok = 0;
  endtask

  task automatic fw_write(logic [7:0] v);
    @(negedge clk); quiet(); cfg_wr = 1; cfg_wdata = v;
    @(posedge clk); #1;
    @(negedge clk); cfg_wr = 0;
  endtask

  // One packet: token, nbytes data bytes, end of packet with CRC status.
  task automatic run_pkt(string req, bit setup, int nbytes, bit good,
                         bit exp_take, logic [1:0] exp_hs, bit exp_rew,
                         bit fw_at_eop, bit fw_mid);
    @(negedge clk); quiet(); tok_setup = setup; tok_out = !setup;
    @(negedge clk); quiet();
    for (int i = 0; i < nbytes; i++) begin
      byte_vld = 1; byte_data = 8'h5A ^ 8'(i * 17);
      if (fw_mid && i == 0) begin cfg_wr = 1; cfg_wdata = 8'h10; end
      #1;
      check({req, " fifo_we"}, fifo_we, exp_take);
      if (exp_take) check({req, " fifo_wdata"}, fifo_wdata, byte_data);
      @(negedge clk); quiet();
    end
    eop = 1; crc_ok = good;
    if (fw_at_eop) begin cfg_wr = 1; cfg_wdata = 8'h10; end
    @(posedge clk); #1;
    check({req, " hs_sel"}, hs_sel, exp_hs);
    check({req, " fifo_rewind"}, fifo_rewind, exp_rew);
    @(negedge clk); quiet();
    @(posedge clk); #1;
    check("R9 strobe width", hs_sel, 2'b00);
  endtask

  task automatic t_reset();
    quiet(); rst = 1;
    repeat (2) @(posedge clk);
    #1;
    check("R1 out_en", out_en, 0);
    check("R1 hs_sel", hs_sel, 0);
    check("R1 fifo_rewind", fifo_rewind, 0);
    check("R1 fifo_we", fifo_we, 0);
    @(negedge clk); rst = 0;
  endtask

  task automatic t_fw_write();
    fw_write(8'h10); check("R2 set", out_en, 1);
    fw_write(8'hEF); check("R2 other bits ignored", out_en, 0);
    fw_write(8'hFF); check("R2 set all", out_en, 1);
    fw_write(8'h00); check("R2 clear", out_en, 0);
  endtask

  task automatic t_out_enabled();
    fw_write(8'h10);
    @(negedge clk); quiet(); tok_out = 1;
    @(posedge clk); #1; check("R5 bit kept after token", out_en, 1);
    run_pkt("R3 R5 enabled OUT", 0, 3, 1, 1, 2'b01, 0, 0, 0);
    check("R5 cleared after ACK", out_en, 0);
  endtask

  task automatic t_out_disabled();
    fw_write(8'h00);
    run_pkt("R4 disabled OUT", 0, 2, 1, 0, 2'b10, 0, 0, 0);
    check("R4 bit still clear", out_en, 0);
    run_pkt("R4 fw arms during NAKed OUT", 0, 2, 1, 0, 2'b10, 0, 0, 1);
    check("R4 NAK keeps bit", out_en, 1);
  endtask

  task automatic t_setup();
    fw_write(8'h10);
    run_pkt("R6 SETUP enabled", 1, 8, 1, 1, 2'b01, 0, 0, 0);
    check("R6 SETUP clears bit", out_en, 0);
    run_pkt("R6 SETUP disabled", 1, 2, 1, 1, 2'b01, 0, 0, 0);
    check("R6 bit stays clear", out_en, 0);
  endtask

  task automatic t_crc_err();
    fw_write(8'h10);
    run_pkt("R7 bad CRC enabled OUT", 0, 3, 0, 1, 2'b00, 1, 0, 0);
    check("R7 bit unchanged", out_en, 1);
    run_pkt("R7 bad CRC SETUP", 1, 2, 0, 1, 2'b00, 1, 0, 0);
    check("R7 bit unchanged after SETUP", out_en, 1);
    fw_write(8'h00);
    run_pkt("R7 bad CRC disabled OUT", 0, 2, 0, 0, 2'b00, 0, 0, 0);
    run_pkt("R7 bad CRC empty SETUP", 1, 0, 0, 1, 2'b00, 0, 0, 0);
  endtask

  task automatic t_collision();
    fw_write(8'h10);
    run_pkt("R8 write at ACK edge", 0, 1, 1, 1, 2'b01, 0, 1, 0);
    check("R8 hardware clear wins", out_en, 0);
  endtask

  task automatic t_stray();
    fw_write(8'h10);
    @(negedge clk); quiet(); byte_vld = 1; byte_data = 8'h33;
    #1; check("R10 stray byte", fifo_we, 0);
    @(negedge clk); quiet(); eop = 1; crc_ok = 1;
    @(posedge clk); #1;
    check("R10 stray eop hs", hs_sel, 2'b00);
    check("R10 bit untouched", out_en, 1);
    @(negedge clk); quiet();
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_fw_write();
    t_out_enabled();
    t_out_disabled();
    t_setup();
    t_crc_err();
    t_collision();
    t_stray();
    repeat (3) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule